// File: doc/BRIEF.md
# I2C SCL Phase Divisor Calculator

This block turns a requested I2C bus rate into the two counts that an SCL generator loads for its low and high phases. A request carries the rate of the generator's input clock and the desired SCL rate, both in kHz. The block picks per-phase minimum durations from the bus timing class of the requested rate and turns them into tick counts. The generator counts eight input clocks per tick. The low and high counts are first set from those minimums. If they already exceed the count needed to stay at or below the requested rate, they are used as they are. Otherwise the spare count is shared out so that the low phase gets about its proportional share of the period.

All arithmetic runs through one shared ceiling divider that produces one quotient bit per cycle. A full calculation therefore takes three or four divisions, with a fixed, known latency for each path. The outputs are reduced by one, because the generator adds one to each count implicitly. They are limited to 16 bits.

The request side is a valid/ready pair. `req_ready` is high only while the block is idle, and a request moves in on a clock edge where both are high. There is no back-pressure on the result: `res_valid` is a single-cycle strobe. The result values stay on the outputs until the next result replaces them.

Top module: `scl_div_engine`

## Requirements
- R1: `req_ready` is high exactly when no calculation is in progress. A request is taken on an edge with `req_valid` and `req_ready` both high. `req_valid` and the rate inputs are ignored while a calculation runs: the outputs, `res_valid` and the result of the running request are unaffected.
- R2: A target rate of at most 100 kHz uses a 5350 ns low minimum and a 4650 ns high minimum. Any faster target uses 1600 ns low and 900 ns high.
- R3: The total count is ceil(src / (8 * tgt)). Each phase minimum count is ceil(src * phase_ns / 8000000). All quantities are unsigned integers.
- R4: When the low and high minimum counts added together exceed the total count, the low and high results are those two minimum counts.
- R5: Otherwise the low count is ceil(src * low_ns / (tgt * 8 * (low_ns + high_ns))), capped at total minus the high minimum count, and the high count is the total minus the low count.
- R6: Each output is its count minus one. A count of 0 gives 0. A decremented value above 65535 gives 65535.
- R7: `rate_err` is updated with each result and is 1 exactly when that request's target rate exceeds 400 kHz. Such a request is computed with the fast minimums.
- R8: `res_valid` is high for one cycle. It comes 151 cycles after the accepting edge when R4 applies and 201 cycles after when R5 applies, with the default 48-bit arithmetic. `div_low`, `div_high` and `rate_err` hold their values between results.
- R9: After reset, `req_ready` is 1 and `res_valid`, `div_low`, `div_high` and `rate_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| src_khz | input | 24 | Generator input clock rate in kHz |
| tgt_khz | input | 24 | Requested SCL rate in kHz |
| res_valid | output | 1 | One-cycle result strobe |
| div_low | output | 16 | Low phase count minus one |
| div_high | output | 16 | High phase count minus one |
| rate_err | output | 1 | Last request was above 400 kHz |

## Verification
The assertions check the following on every cycle. Each divider quotient is the exact floor of its adjusted numerator. The result strobe and the divider's done strobe last one cycle. Accepting a request drops `req_ready`. The error flag matches the latched target. On the headroom path, the two unsaturated outputs plus two add up to the total count. The bench must show the rest through its scenarios. That covers the choice between the two timing classes and the exact latency of each path. It also covers the cap on the low count, the floor at zero, saturation, and requests driven during a busy calculation being ignored. It compares every output on every clock against a behavioural model.

// File: rtl/scl_div_pkg.sv
package scl_div_pkg;
  localparam int NS_W = 14;
  localparam logic [NS_W-1:0] STD_LOW_NS   = 14'd5350;
  localparam logic [NS_W-1:0] STD_HIGH_NS  = 14'd4650;
  localparam logic [NS_W-1:0] FAST_LOW_NS  = 14'd1600;
  localparam logic [NS_W-1:0] FAST_HIGH_NS = 14'd900;
  localparam int STD_MAX_KHZ  = 100;
  localparam int FAST_MAX_KHZ = 400;
  // ticks of 8 input clocks, rate in kHz, time in ns: 8 * 1e6
  localparam int NS_TICK_SCALE = 8_000_000;

  typedef enum logic [1:0] {PH_IDLE, PH_GO, PH_WAIT, PH_DECIDE} phase_e;
  typedef enum logic [1:0] {OP_TOTAL, OP_LOW, OP_HIGH, OP_IDEAL} op_e;
endpackage

// File: rtl/scl_phase_min_sel.sv
module scl_phase_min_sel
  import scl_div_pkg::*;
#(
  parameter int RATE_W = 24
) (
  input  logic [RATE_W-1:0] tgt_khz,
  output logic [NS_W-1:0]   low_ns,
  output logic [NS_W-1:0]   high_ns,
  output logic              over_fast
);
  logic is_std;

  always_comb begin
    is_std    = (tgt_khz <= RATE_W'(STD_MAX_KHZ));
    over_fast = (tgt_khz >  RATE_W'(FAST_MAX_KHZ));
    low_ns    = is_std ? STD_LOW_NS  : FAST_LOW_NS;
    high_ns   = is_std ? STD_HIGH_NS : FAST_HIGH_NS;
  end
endmodule

// File: rtl/scl_ceil_div.sv
module scl_ceil_div #(
  parameter int W = 48
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] num_i,
  input  logic [W-1:0] den_i,
  output logic         done_o,
  output logic [W-1:0] quot_o
);
  localparam int CW = $clog2(W + 1);
  localparam int W2 = 2 * W;

  logic [W-1:0]  rem_r, quo_r, den_r, num_r;
  logic [CW-1:0] cnt_r;
  logic          busy_r, done_r;
  logic [W:0]    rem_sh;
  logic [W-1:0]  rem_try;
  logic          take;
  logic [W-1:0]  adj_num;

  always_comb begin
    adj_num = num_i + den_i - W'(1);
    rem_sh  = {rem_r, quo_r[W-1]};
    take    = (rem_sh >= {1'b0, den_r});
    rem_try = rem_sh[W-1:0] - den_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_r  <= '0;
      quo_r  <= '0;
      den_r  <= '0;
      num_r  <= '0;
      cnt_r  <= '0;
      busy_r <= 1'b0;
      done_r <= 1'b0;
    end else begin
      done_r <= 1'b0;
      if (start && !busy_r) begin
        rem_r  <= '0;
        quo_r  <= adj_num;
        num_r  <= adj_num;
        den_r  <= den_i;
        cnt_r  <= CW'(W);
        busy_r <= 1'b1;
      end else if (busy_r) begin
        rem_r <= take ? rem_try : rem_sh[W-1:0];
        quo_r <= {quo_r[W-2:0], take};
        cnt_r <= cnt_r - CW'(1);
        if (cnt_r == CW'(1)) begin
          busy_r <= 1'b0;
          done_r <= 1'b1;
        end
      end
    end
  end

  assign done_o = done_r;
  assign quot_o = quo_r;

  logic [W2-1:0] chk_lo, chk_hi;
  always_comb begin
    chk_lo = W2'(quo_r) * W2'(den_r);
    chk_hi = chk_lo + W2'(den_r);
  end

  assert_quotient_exact_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_r && den_r != '0) |-> (chk_lo <= W2'(num_r) && chk_hi > W2'(num_r)));

  assert_div_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_r |=> !done_r);
endmodule

// File: rtl/scl_div_finalize.sv
module scl_div_finalize #(
  parameter int IW = 48,
  parameter int OW = 16
) (
  input  logic [IW-1:0] cnt_i,
  output logic [OW-1:0] val_o
);
  logic [IW-1:0] dec;

  always_comb begin
    dec = cnt_i - IW'(1);
    if (cnt_i == '0)
      val_o = '0;
    else if (dec > IW'({OW{1'b1}}))
      val_o = '1;
    else
      val_o = dec[OW-1:0];
  end
endmodule

// File: rtl/scl_div_engine.sv
module scl_div_engine
  import scl_div_pkg::*;
#(
  parameter int RATE_W = 24,
  parameter int PROD_W = 48,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [RATE_W-1:0] src_khz,
  input  logic [RATE_W-1:0] tgt_khz,
  output logic              res_valid,
  output logic [DIV_W-1:0]  div_low,
  output logic [DIV_W-1:0]  div_high,
  output logic              rate_err
);
  phase_e            phase_r;
  op_e               op_r;
  logic [RATE_W-1:0] src_q, tgt_q;
  logic [PROD_W-1:0] tot_q, mlow_q, mhigh_q;
  logic [DIV_W-1:0]  lo_r, hi_r;
  logic              err_r, valid_r;

  logic [NS_W-1:0]   low_ns, high_ns;
  logic              over_fast;
  logic              cd_start, cd_done;
  logic [PROD_W-1:0] cd_num, cd_den, cd_quot;
  logic [PROD_W-1:0] cap, split_lo, split_hi, fin_lo_in, fin_hi_in;
  logic [DIV_W-1:0]  fin_lo, fin_hi;
  logic [PROD_W-1:0] src_w, tgt_w, sum_ns_w;

  scl_phase_min_sel #(.RATE_W(RATE_W)) u_sel (
    .tgt_khz  (tgt_q),
    .low_ns   (low_ns),
    .high_ns  (high_ns),
    .over_fast(over_fast)
  );

  // operand selection for the shared divider
  always_comb begin
    src_w    = PROD_W'(src_q);
    tgt_w    = PROD_W'(tgt_q);
    sum_ns_w = PROD_W'(low_ns) + PROD_W'(high_ns);
    cd_start = (phase_r == PH_GO);
    case (op_r)
      OP_TOTAL: begin
        cd_num = src_w;
        cd_den = tgt_w * PROD_W'(8);
      end
      OP_LOW: begin
        cd_num = src_w * PROD_W'(low_ns);
        cd_den = PROD_W'(NS_TICK_SCALE);
      end
      OP_HIGH: begin
        cd_num = src_w * PROD_W'(high_ns);
        cd_den = PROD_W'(NS_TICK_SCALE);
      end
      default: begin
        cd_num = src_w * PROD_W'(low_ns);
        cd_den = tgt_w * PROD_W'(8) * sum_ns_w;
      end
    endcase
  end

  scl_ceil_div #(.W(PROD_W)) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .start (cd_start),
    .num_i (cd_num),
    .den_i (cd_den),
    .done_o(cd_done),
    .quot_o(cd_quot)
  );

  // headroom split: low takes its share up to the cap, high gets the rest
  always_comb begin
    cap       = tot_q - mhigh_q;
    split_lo  = (cd_quot > cap) ? cap : cd_quot;
    split_hi  = tot_q - split_lo;
    fin_lo_in = (op_r == OP_IDEAL) ? split_lo : mlow_q;
    fin_hi_in = (op_r == OP_IDEAL) ? split_hi : mhigh_q;
  end

  scl_div_finalize #(.IW(PROD_W), .OW(DIV_W)) u_fin_lo (
    .cnt_i(fin_lo_in),
    .val_o(fin_lo)
  );

  scl_div_finalize #(.IW(PROD_W), .OW(DIV_W)) u_fin_hi (
    .cnt_i(fin_hi_in),
    .val_o(fin_hi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_r <= PH_IDLE;
      op_r    <= OP_TOTAL;
      src_q   <= '0;
      tgt_q   <= '0;
      tot_q   <= '0;
      mlow_q  <= '0;
      mhigh_q <= '0;
      lo_r    <= '0;
      hi_r    <= '0;
      err_r   <= 1'b0;
      valid_r <= 1'b0;
    end else begin
      valid_r <= 1'b0;
      case (phase_r)
        PH_IDLE: begin
          if (req_valid) begin
            src_q   <= src_khz;
            tgt_q   <= tgt_khz;
            op_r    <= OP_TOTAL;
            phase_r <= PH_GO;
          end
        end
        PH_GO: phase_r <= PH_WAIT;
        PH_WAIT: begin
          if (cd_done) begin
            case (op_r)
              OP_TOTAL: begin
                tot_q   <= cd_quot;
                op_r    <= OP_LOW;
                phase_r <= PH_GO;
              end
              OP_LOW: begin
                mlow_q  <= cd_quot;
                op_r    <= OP_HIGH;
                phase_r <= PH_GO;
              end
              OP_HIGH: begin
                mhigh_q <= cd_quot;
                phase_r <= PH_DECIDE;
              end
              default: begin
                lo_r    <= fin_lo;
                hi_r    <= fin_hi;
                err_r   <= over_fast;
                valid_r <= 1'b1;
                phase_r <= PH_IDLE;
              end
            endcase
          end
        end
        PH_DECIDE: begin
          if (mlow_q + mhigh_q > tot_q) begin
            lo_r    <= fin_lo;
            hi_r    <= fin_hi;
            err_r   <= over_fast;
            valid_r <= 1'b1;
            phase_r <= PH_IDLE;
          end else begin
            op_r    <= OP_IDEAL;
            phase_r <= PH_GO;
          end
        end
        default: phase_r <= PH_IDLE;
      endcase
    end
  end

  assign req_ready = (phase_r == PH_IDLE);
  assign res_valid = valid_r;
  assign div_low   = lo_r;
  assign div_high  = hi_r;
  assign rate_err  = err_r;

  assert_accept_drops_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  assert_result_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  assert_error_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (rate_err == (tgt_q > RATE_W'(FAST_MAX_KHZ))));

  assert_split_sum_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && op_r == OP_IDEAL && tot_q < PROD_W'(65536) &&
     div_low != '0 && div_high != '0)
    |-> (PROD_W'(div_low) + PROD_W'(div_high) + PROD_W'(2) == tot_q));
endmodule

// File: tb/scl_div_engine_tb_top.sv
module scl_div_engine_tb_top;
  localparam int OP_CYC    = 48 + 2;
  localparam int LAT_HOLD  = 3 * OP_CYC + 1;
  localparam int LAT_SPLIT = 4 * OP_CYC + 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] src_khz = '0;
  logic [23:0] tgt_khz = '0;
  logic        res_valid;
  logic [15:0] div_low, div_high;
  logic        rate_err;

  always #5 clk = ~clk;

  scl_div_engine dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .src_khz(src_khz), .tgt_khz(tgt_khz), .res_valid(res_valid),
    .div_low(div_low), .div_high(div_high), .rate_err(rate_err)
  );

  int nchk = 0;
  int nerr = 0;
  bit run_chk = 0;
  bit m_busy = 0;
  int m_n = 0;
  int m_lat = 0;
  bit m_hold = 0;
  string m_tag = "R3";
  longint m_lo_new = 0, m_hi_new = 0, m_lo_old = 0, m_hi_old = 0;
  bit m_err_new = 0, m_err_old = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic longint cdiv(input longint a, input longint b);
    return (a + b - 1) / b;
  endfunction

  function automatic longint fin(input longint v);
    if (v == 0) return 0;
    if (v - 1 > 65535) return 65535;
    return v - 1;
  endfunction

  task automatic model(input longint c, input longint s);
    longint lns, hns, tot, ml, mh, ideal, lo, hi;
    lns = (s <= 100) ? 5350 : 1600;
    hns = (s <= 100) ? 4650 : 900;
    tot = cdiv(c, 8 * s);
    ml  = cdiv(c * lns, 8000000);
    mh  = cdiv(c * hns, 8000000);
    if (ml + mh > tot) begin
      lo = ml; hi = mh; m_hold = 1;
    end else begin
      ideal = cdiv(c * lns, s * 8 * (lns + hns));
      lo = (ideal > tot - mh) ? tot - mh : ideal;
      hi = tot - lo;
      m_hold = 0;
    end
    m_lo_new  = fin(lo);
    m_hi_new  = fin(hi);
    m_err_new = (s > 400);
    m_lat     = m_hold ? LAT_HOLD : LAT_SPLIT;
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (rst_n && run_chk) begin
      if (m_busy) begin
        m_n++;
        chk(req_ready == (m_n >= m_lat), "R1 ready", req_ready, m_n >= m_lat);
        chk(res_valid == (m_n == m_lat), "R8 strobe", res_valid, m_n == m_lat);
        if (m_n == m_lat) begin
          chk(div_low == m_lo_new, m_hold ? "R4 low" : "R5 low", div_low, m_lo_new);
          chk(div_high == m_hi_new, m_hold ? "R4 high" : "R5 high", div_high, m_hi_new);
          chk(rate_err == m_err_new, "R7 err", rate_err, m_err_new);
          chk(1'b1, m_tag, 0, 0);
          m_lo_old = m_lo_new; m_hi_old = m_hi_new; m_err_old = m_err_new;
          m_busy = 0;
        end else begin
          chk(div_low == m_lo_old, "R8 hold low", div_low, m_lo_old);
          chk(div_high == m_hi_old, "R8 hold high", div_high, m_hi_old);
          chk(rate_err == m_err_old, "R8 hold err", rate_err, m_err_old);
        end
      end else begin
        chk(req_ready == 1'b1, "R1 idle ready", req_ready, 1);
        chk(res_valid == 1'b0, "R8 idle strobe", res_valid, 0);
        chk(div_low == m_lo_old, "R8 idle low", div_low, m_lo_old);
        chk(div_high == m_hi_old, "R8 idle high", div_high, m_hi_old);
      end
    end
  end

  task automatic send(input longint c, input longint s, input string tag, input bit junk);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    src_khz = 24'(c);
    tgt_khz = 24'(s);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    m_tag = tag;
    model(c, s);
    m_n = -1;
    m_busy = 1;
    if (junk) begin
      // R1: requests offered while busy must be ignored
      for (int k = 0; k < 20; k++) begin
        @(negedge clk);
        req_valid = 1'b1;
        src_khz = 24'd12345;
        tgt_khz = 24'd7;
      end
      @(negedge clk);
      req_valid = 1'b0;
    end
    while (m_busy) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    int unsigned seed;
    longint c, s;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9: reset values
    chk(req_ready == 1'b1, "R9 ready", req_ready, 1);
    chk(res_valid == 1'b0, "R9 strobe", res_valid, 0);
    chk(div_low == 16'd0, "R9 low", div_low, 0);
    chk(div_high == 16'd0, "R9 high", div_high, 0);
    chk(rate_err == 1'b0, "R9 err", rate_err, 0);
    rst_n = 1'b1;
    run_chk = 1;
    send(24000, 100, "R2 standard hold-bound", 0);
    send(24000, 400, "R2 fast zero headroom", 0);
    send(100000, 100, "R4 hold-bound", 0);
    send(100000, 50, "R5 headroom split", 1);
    send(24000, 350, "R5 fast split", 0);
    send(24000, 1000, "R7 above fast", 0);
    send(0, 100, "R6 zero floor", 0);
    send(16000000, 10, "R6 saturation", 0);
    send(50000, 101, "R2 boundary fast", 1);
    send(50000, 401, "R7 boundary", 0);
    send(48000, 1, "R3 slow target", 0);
    seed = 32'h1234abcd;
    for (int i = 0; i < 180; i++) begin
      seed = seed * 1664525 + 1013904223;
      c = longint'(seed % 400000);
      seed = seed * 1664525 + 1013904223;
      s = 1 + longint'(seed % 600);
      send(c, s, "R3 sweep", (i % 7) == 0);
    end
    run_chk = 0;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule